// File: doc/BRIEF.md
# Dual-Rail Power-On Reset Sequencer

This block holds two active-low reset outputs, one for a standby supply and one for a main supply, until each rail has been good for a fixed hold time. Each rail comes in as a supply-good flag from an external comparator. A free-running clock times the hold, and the hold length is set in milliseconds together with the clock frequency. The standby flag also acts as the block's own reset. While it is low, every register inside is cleared.

Each output is driven by its own timer state machine. The three states are `ST_IDLE` (rail not good, output held low), `ST_COUNT` (rail good, counting the hold) and `ST_DONE` (output released). The transitions are:
- *arm*: `ST_IDLE`→`ST_COUNT`, taken when the go condition is seen high.
- *expire*: `ST_COUNT`→`ST_DONE`, taken when the count reaches the hold length.
- *abort*: `ST_COUNT`→`ST_IDLE`, taken when go drops.
- *drop*: `ST_DONE`→`ST_IDLE`, taken when go drops.

The main timer's go condition is its supply-good flag. The standby timer's go condition depends on the order in which the rails came up:
- If the main rail was already good on the cycle the core supply flag first rose ("main-first" ordering), standby go is held until the main reset output has been released.
- Otherwise standby go is always high.

The main reset pin is open-drain and bidirectional. Its level comes back through `main_pin_i`. The block may see the pin low while it is not driving it low itself. In that case it raises a one-cycle register-reset request on the falling edge of the synchronised pin level, which returns the register file to its defaults. All supply-good inputs are assumed synchronous to `clk`.

Top module: `dual_por_gen`

## Requirements
- R1: While `sby_good_i` is 0, after one rising edge both `sby_rst_n_o` and `main_rst_n_o` are 0 and `reg_rst_req_o` is 0.
- R2: With standby go high, `sby_rst_n_o` rises on the (HOLD+1)-th consecutive rising edge at which go is high, where HOLD = CLK_HZ*HOLD_MS/1000. It is still 0 after HOLD such edges.
- R3: With `main_good_i` high, `main_rst_n_o` rises on the (HOLD+1)-th consecutive rising edge at which `main_good_i` is high. It is still 0 after HOLD such edges.
- R4: A 0 on `main_good_i` makes `main_rst_n_o` 0 after the next rising edge. A later rise of `main_good_i` needs the full HOLD+1 edges again.
- R5: When `main_good_i` is 1 on the first edge at which `core_good_i` is seen high, the standby reset is released exactly HOLD+1 edges after the edge that releases `main_rst_n_o`.
- R6: When `core_good_i` rises while `main_good_i` is 0, a later rise of `main_good_i` leaves `sby_rst_n_o` unchanged.
- R7: With `main_rst_n_o` at 1, a low on `main_pin_i` gives exactly one `reg_rst_req_o` cycle, high after the third rising edge, and `main_rst_n_o` stays 1.
- R8: A low on `main_pin_i` while the block drives `main_rst_n_o` low, held until after release, produces no `reg_rst_req_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timing clock |
| sby_good_i | input | 1 | Standby rail above threshold; low clears the block |
| main_good_i | input | 1 | Main rail above threshold |
| core_good_i | input | 1 | Core logic supply good, used for ordering |
| main_pin_i | input | 1 | Sensed level of the open-drain main reset pin |
| sby_rst_n_o | output | 1 | Standby reset, active low |
| main_rst_n_o | output | 1 | Main reset drive, active low (0 pulls the pin low) |
| reg_rst_req_o | output | 1 | One-cycle register default-restore request |

## Verification
A timer FSM stuck in or skipping `ST_COUNT` shows up as a reset output that rises one or more edges away from HOLD+1. A failure to return to `ST_IDLE` on a rail drop leaves an output high one edge after the drop. A wrongly latched ordering flag makes the standby release land either together with the main count or a whole HOLD late. The bench checks both edges of every release window, so an off-by-one is seen within a single cycle. Mistakes in the pin edge detector show as a missing, doubled or mis-timed request pulse, or as a spurious pulse, within three edges of the pin change.

// File: rtl/por_pkg.sv
package por_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2
    } por_state_e;

    function automatic longint unsigned hold_cycles(input longint unsigned clk_hz,
                                                    input longint unsigned hold_ms);
        return (clk_hz * hold_ms) / 64'd1000;
    endfunction

endpackage

// File: rtl/por_hold_timer.sv
module por_hold_timer
    import por_pkg::*;
#(
    parameter int unsigned HOLD = 180
) (
    input  logic clk,
    input  logic clr,
    input  logic go,
    output logic rel
);
    localparam int unsigned CW = $clog2(HOLD + 1);

    por_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (go) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!go) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == CW'(HOLD - 1)) begin
                    state_d = ST_DONE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_DONE: begin
                cnt_d = '0;
                if (!go) state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        rel = (state_q == ST_DONE);
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (clr)
        cnt_q < CW'(HOLD)) else $error("count beyond hold"); // R2

    AST_GO_LOW_DROPS: assert property (@(posedge clk) disable iff (clr)
        !go |=> !rel) else $error("release held while go low"); // R4

endmodule

// File: rtl/por_pin_detect.sv
module por_pin_detect (
    input  logic clk,
    input  logic clr,
    input  logic released,
    input  logic pin,
    output logic req
);
    logic s1_q, s2_q, s3_q, req_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            s3_q  <= 1'b0;
            req_q <= 1'b0;
        end else begin
            s1_q  <= pin;
            s2_q  <= s1_q;
            s3_q  <= s2_q;
            req_q <= released & s3_q & ~s2_q;
        end
    end

    always_comb begin
        req = req_q;
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (clr)
        req |=> !req) else $error("request longer than one cycle"); // R7

    AST_REQ_ONLY_RELEASED: assert property (@(posedge clk) disable iff (clr)
        req |-> $past(released)) else $error("request while driving low"); // R8

endmodule

// File: rtl/dual_por_gen.sv
module dual_por_gen
    import por_pkg::*;
#(
    parameter longint unsigned CLK_HZ  = 50_000_000,
    parameter longint unsigned HOLD_MS = 180
) (
    input  logic clk,
    input  logic sby_good_i,
    input  logic main_good_i,
    input  logic core_good_i,
    input  logic main_pin_i,
    output logic sby_rst_n_o,
    output logic main_rst_n_o,
    output logic reg_rst_req_o
);
    localparam int unsigned HOLD = int'(hold_cycles(CLK_HZ, HOLD_MS));

    logic clr;
    logic core_q;
    logic main_lead_q;
    logic sby_go;
    logic sby_rel, main_rel;

    always_comb begin
        clr = ~sby_good_i;
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            core_q      <= 1'b0;
            main_lead_q <= 1'b0;
        end else begin
            core_q <= core_good_i;
            if (core_good_i && !core_q) main_lead_q <= main_good_i;
        end
    end

    always_comb begin
        sby_go = ~main_lead_q | main_rel;
    end

    por_hold_timer #(.HOLD(HOLD)) u_sby_tmr (
        .clk (clk),
        .clr (clr),
        .go  (sby_go),
        .rel (sby_rel)
    );

    por_hold_timer #(.HOLD(HOLD)) u_main_tmr (
        .clk (clk),
        .clr (clr),
        .go  (main_good_i),
        .rel (main_rel)
    );

    por_pin_detect u_pin_det (
        .clk      (clk),
        .clr      (clr),
        .released (main_rel),
        .pin      (main_pin_i),
        .req      (reg_rst_req_o)
    );

    always_comb begin
        sby_rst_n_o  = sby_rel;
        main_rst_n_o = main_rel;
    end

    AST_CLEAR_HOLDS: assert property (@(posedge clk)
        !sby_good_i |=> (!sby_rst_n_o && !main_rst_n_o && !reg_rst_req_o))
        else $error("outputs not cleared"); // R1

    AST_MAIN_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!sby_good_i)
        $rose(main_rst_n_o) |-> $past(main_good_i)) else $error("main released while bad"); // R3

    AST_MAIN_DROP: assert property (@(posedge clk) disable iff (!sby_good_i)
        !main_good_i |=> !main_rst_n_o) else $error("main reset not reasserted"); // R4

    AST_SBY_WAITS_MAIN: assert property (@(posedge clk) disable iff (!sby_good_i)
        (main_lead_q && !main_rst_n_o) |=> !sby_rst_n_o) else $error("standby released early"); // R5

endmodule

// File: tb/dual_por_gen_tb_top.sv
module dual_por_gen_tb_top;
    localparam int unsigned H = 180;

    logic clk = 1'b0;
    logic sby = 1'b0, mg = 1'b0, cg = 1'b0, ext_n = 1'b1;
    logic pin;
    logic sby_n, main_n, req;
    int checks = 0, fails = 0, req_cnt = 0;

    always #10 clk = ~clk;

    assign pin = main_n & ext_n;

    dual_por_gen #(.CLK_HZ(1000), .HOLD_MS(180)) dut_i (
        .clk (clk), .sby_good_i (sby), .main_good_i (mg), .core_good_i (cg),
        .main_pin_i (pin), .sby_rst_n_o (sby_n), .main_rst_n_o (main_n),
        .reg_rst_req_o (req)
    );

    typedef struct packed {
        logic s; logic m; logic c; logic e;
        logic [31:0] n;
        logic xs; logic xm;
    } vec_t;

    localparam vec_t TBL [11] = '{
        '{1'b0,1'b0,1'b0,1'b1, 32'd3,     1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b1, 32'(H),    1'b0,1'b0},
        '{1'b1,1'b0,1'b0,1'b1, 32'd1,     1'b1,1'b0},
        '{1'b1,1'b1,1'b0,1'b1, 32'(H),    1'b1,1'b0},
        '{1'b1,1'b1,1'b0,1'b1, 32'd1,     1'b1,1'b1},
        '{1'b1,1'b0,1'b0,1'b1, 32'd1,     1'b1,1'b0},
        '{1'b1,1'b1,1'b0,1'b1, 32'(H/2),  1'b1,1'b0},
        '{1'b1,1'b0,1'b0,1'b1, 32'd1,     1'b1,1'b0},
        '{1'b1,1'b1,1'b0,1'b1, 32'(H),    1'b1,1'b0},
        '{1'b1,1'b1,1'b0,1'b1, 32'd1,     1'b1,1'b1},
        '{1'b0,1'b1,1'b0,1'b1, 32'd1,     1'b0,1'b0}
    };

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (req) req_cnt++;
        end
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        // Table: R1 reset state, R2 standby release, R3 main release, R4 restart
        foreach (TBL[i]) begin
            sby = TBL[i].s; mg = TBL[i].m; cg = TBL[i].c; ext_n = TBL[i].e;
            req_cnt = 0;
            run(int'(TBL[i].n));
            chk($sformatf("R1/R2/R4 row%0d sby_rst_n", i), sby_n, TBL[i].xs);
            chk($sformatf("R1/R3/R4 row%0d main_rst_n", i), main_n, TBL[i].xm);
        end
        chk("R1 no request while cleared", req, 1'b0);

        // R5: main good before core rises -> standby follows main release
        sby = 1; mg = 1; cg = 1;
        run(H);
        chk("R5 main still held", main_n, 1'b0);
        run(1);
        chk("R5 main released", main_n, 1'b1);
        chk("R5 sby held at main release", sby_n, 1'b0);
        run(H);
        chk("R5 sby held HOLD after main", sby_n, 1'b0);
        run(1);
        chk("R5 sby released HOLD+1 after main", sby_n, 1'b1);

        // R6: core rises first -> main rise does not disturb standby
        sby = 0; mg = 0; cg = 0;
        run(2);
        sby = 1; cg = 1;
        run(H + 1);
        chk("R6 sby released without main", sby_n, 1'b1);
        mg = 1;
        run(5);
        chk("R6 sby unaffected by main rise", sby_n, 1'b1);
        run(H);
        chk("R6 main released", main_n, 1'b1);
        chk("R6 sby still released", sby_n, 1'b1);

        // R7: external pull while released
        req_cnt = 0;
        ext_n = 0;
        run(2);
        chk("R7 no request before 3rd edge", req, 1'b0);
        run(1);
        chk("R7 request after 3rd edge", req, 1'b1);
        run(1);
        chk("R7 request one cycle", req, 1'b0);
        run(6);
        chk_int("R7 exactly one pulse", req_cnt, 1);
        chk("R7 main output not asserted by pin", main_n, 1'b1);
        ext_n = 1;
        run(5);

        // R8: external pull while block drives low, held across release
        mg = 0;
        run(2);
        req_cnt = 0;
        ext_n = 0;
        run(5);
        mg = 1;
        run(H + 1);
        chk("R8 main released under external low", main_n, 1'b1);
        run(6);
        chk_int("R8 no request pulse", req_cnt, 0);
        ext_n = 1;
        run(5);
        chk_int("R8 no request on pin rise", req_cnt, 0);

        // R1: standby loss clears everything in one edge
        sby = 0;
        run(1);
        chk("R1 sby cleared", sby_n, 1'b0);
        chk("R1 main cleared", main_n, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule